// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between the load/store stage of a 32-bit pipeline and a 32-bit little-endian data port. On the request side it takes an opcode, a base register value, a 16-bit offset and the source register value. One cycle later it presents the following to the memory port:

- the effective address,
- a write flag,
- four byte-lane enables,
- write data steered onto the correct lanes.

On the response side it takes the returned memory word, the low two address bits of the access and the old contents of the destination register. One cycle later it presents the value to write back. That value is sign- or zero-extended for the narrow loads and merged with the old register bytes for the unaligned left/right word loads.

Both paths cover byte, halfword and word accesses, plus the unaligned left/right variants. Those variants let software assemble a misaligned word from two accesses. The block raises no alignment faults and has no notion of memory latency. The pipeline is responsible for presenting the response when the data arrives.

Opcodes (6-bit, decimal):

| Opcode | Operation |
|---|---|
| 32 | signed byte load |
| 33 | signed halfword load |
| 34 | left word load |
| 35 | word load |
| 36 | unsigned byte load |
| 37 | unsigned halfword load |
| 38 | right word load |
| 40 | byte store |
| 41 | halfword store |
| 42 | left word store |
| 43 | word store |
| 46 | right word store |

In the requirements, k denotes the low two address bits, and register byte n is bits 8n+7:8n.

Top module: `lsu_lane_align`

## Requirements
- R1: For any recognised opcode with `req_valid` high, the next cycle shows `mem_valid` high and `mem_addr` equal to `base` plus `offset` sign-extended to 32 bits.
- R2: A byte store (40) enables only lane k and places register byte 0 on that lane, with `mem_we` high.
- R3: A halfword store (41) enables lanes 0-1 when address bit 1 is 0, or lanes 2-3 when it is 1, and places register bytes 0-1 on those lanes in order.
- R4: A word store (43) enables all four lanes and writes the whole register, with register byte n on lane n.
- R5: A left word store (42) at offset k enables lanes 0 to k only, and lane j carries register byte 3-k+j.
- R6: A right word store (46) at offset k enables lanes k to 3 only, and lane j carries register byte j-k.
- R7: A load request (opcodes 32-38) shows `mem_we` low and all four lanes enabled. Data on lanes whose enable is low is unspecified.
- R8: A response for a byte load returns memory byte k, sign-extended for opcode 32 and zero-extended for opcode 36, on `wb_data` one cycle after `rsp_valid`.
- R9: A response for a halfword load returns the halfword selected by address bit 1, sign-extended for opcode 33 and zero-extended for opcode 37.
- R10: A response for a word load (35) returns the memory word unchanged.
- R11: A left word load (34) at offset k writes memory bytes 0 to k into register bytes 3-k to 3 and keeps the other bytes of `rsp_old`.
- R12: A right word load (38) at offset k writes memory bytes k to 3 into register bytes 0 to 3-k and keeps the other bytes of `rsp_old`.
- R13: An unrecognised request opcode, or `req_valid` low, gives `mem_valid` low the next cycle. A response whose opcode is not a load, or `rsp_valid` low, gives `wb_valid` low the next cycle.
- R14: While reset is asserted and in the first cycle after it, `mem_valid` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 6 | Request opcode |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed address displacement |
| rt_data | input | 32 | Source register value for stores |
| mem_valid | output | 1 | Memory access present |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-steered write data |
| rsp_valid | input | 1 | Load response present |
| rsp_op | input | 6 | Opcode of the load being completed |
| rsp_addr_lo | input | 2 | Low address bits of that load |
| rsp_rdata | input | 32 | Word returned by memory |
| rsp_old | input | 32 | Old destination register contents |
| wb_valid | output | 1 | Write-back value present |
| wb_data | output | 32 | Value to write to the register |

## Verification
The only state in this block is its single rank of output registers. A wrong lane shift or mask therefore shows up on `mem_be`, `mem_wdata` or `wb_data` in the cycle right after the offending request or response.

Most errors affect only certain values of k, so the bench drives every offset for each unaligned variant. It also checks that bytes which must be kept from `rsp_old` survive the merge.

A broken valid qualification shows up as a `mem_valid` or `wb_valid` pulse, or a missing one, in that same next cycle. The scoreboard compares every cycle, including idle and rejected ones.

// File: rtl/lsu_lane_align.sv
module lsu_lane_align (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [5:0]  req_op,
  input  logic [31:0] base,
  input  logic [15:0] offset,
  input  logic [31:0] rt_data,
  output logic        mem_valid,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        rsp_valid,
  input  logic [5:0]  rsp_op,
  input  logic [1:0]  rsp_addr_lo,
  input  logic [31:0] rsp_rdata,
  input  logic [31:0] rsp_old,
  output logic        wb_valid,
  output logic [31:0] wb_data
);
  localparam logic [5:0] OP_LB  = 6'd32, OP_LH  = 6'd33, OP_LWL = 6'd34, OP_LW  = 6'd35;
  localparam logic [5:0] OP_LBU = 6'd36, OP_LHU = 6'd37, OP_LWR = 6'd38;
  localparam logic [5:0] OP_SB  = 6'd40, OP_SH  = 6'd41, OP_SWL = 6'd42, OP_SW  = 6'd43;
  localparam logic [5:0] OP_SWR = 6'd46;

  logic [31:0] ea;
  logic [1:0]  k;
  logic        req_known, req_store;
  logic [3:0]  be_n;
  logic [31:0] wd_n;

  assign ea = base + {{16{offset[15]}}, offset};
  assign k  = ea[1:0];

  always_comb begin
    req_known = 1'b1;
    req_store = 1'b1;
    be_n      = 4'b1111;
    wd_n      = 32'h0;
    unique case (req_op)
      OP_SB:  begin be_n = 4'b0001 << k;                 wd_n = {4{rt_data[7:0]}}; end
      OP_SH:  begin be_n = ea[1] ? 4'b1100 : 4'b0011;    wd_n = {2{rt_data[15:0]}}; end
      OP_SW:  begin be_n = 4'b1111;                      wd_n = rt_data; end
      OP_SWL: begin be_n = 4'b1111 >> (2'd3 - k);        wd_n = rt_data >> {2'd3 - k, 3'b000}; end
      OP_SWR: begin be_n = 4'b1111 << k;                 wd_n = rt_data << {k, 3'b000}; end
      OP_LB, OP_LH, OP_LWL, OP_LW, OP_LBU, OP_LHU, OP_LWR: req_store = 1'b0;
      default: begin req_known = 1'b0; req_store = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= 32'h0;
      mem_be    <= 4'h0;
      mem_wdata <= 32'h0;
    end else begin
      mem_valid <= req_valid && req_known;
      mem_we    <= req_valid && req_store;
      mem_addr  <= ea;
      mem_be    <= be_n;
      mem_wdata <= wd_n;
    end
  end

  logic [31:0] rd_shr, lwl_mask, lwr_mask;
  logic [7:0]  rbyte;
  logic [15:0] rhalf;
  logic        rsp_load;
  logic [31:0] wb_n;

  assign rd_shr   = rsp_rdata >> {rsp_addr_lo, 3'b000};
  assign rbyte    = rd_shr[7:0];
  assign rhalf    = rsp_addr_lo[1] ? rsp_rdata[31:16] : rsp_rdata[15:0];
  assign lwl_mask = 32'hFFFF_FFFF << {2'd3 - rsp_addr_lo, 3'b000};
  assign lwr_mask = 32'hFFFF_FFFF >> {rsp_addr_lo, 3'b000};

  always_comb begin
    rsp_load = 1'b1;
    wb_n     = rsp_rdata;
    unique case (rsp_op)
      OP_LB:  wb_n = {{24{rbyte[7]}}, rbyte};
      OP_LBU: wb_n = {24'h0, rbyte};
      OP_LH:  wb_n = {{16{rhalf[15]}}, rhalf};
      OP_LHU: wb_n = {16'h0, rhalf};
      OP_LW:  wb_n = rsp_rdata;
      OP_LWL: wb_n = (rsp_rdata << {2'd3 - rsp_addr_lo, 3'b000}) | (rsp_old & ~lwl_mask);
      OP_LWR: wb_n = rd_shr | (rsp_old & ~lwr_mask);
      default: rsp_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_data  <= 32'h0;
    end else begin
      wb_valid <= rsp_valid && rsp_load;
      wb_data  <= wb_n;
    end
  end

  p_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_known |=> mem_valid && mem_addr == $past(base) + {{16{$past(offset[15])}}, $past(offset)});
  p_store_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_be != 4'h0);
  p_load_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_we |-> mem_be == 4'hF);
  p_byte_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == OP_SB |=> $countones(mem_be) == 1);
  p_lwl_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_op == OP_LWL && rsp_addr_lo == 2'd3 |=> wb_data == $past(rsp_rdata));
  p_lwr_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_op == OP_LWR && rsp_addr_lo == 2'd0 |=> wb_data == $past(rsp_rdata));
  p_req_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !mem_valid);
  p_rsp_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |=> !wb_valid);
endmodule

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_op = 6'd0;
  logic [31:0] base = 32'h0;
  logic [15:0] offset = 16'h0;
  logic [31:0] rt_data = 32'h0;
  logic        mem_valid, mem_we, wb_valid;
  logic [31:0] mem_addr, mem_wdata, wb_data;
  logic [3:0]  mem_be;
  logic        rsp_valid = 1'b0;
  logic [5:0]  rsp_op = 6'd0;
  logic [1:0]  rsp_addr_lo = 2'd0;
  logic [31:0] rsp_rdata = 32'h0;
  logic [31:0] rsp_old = 32'h0;

  always #4 clk = ~clk;

  lsu_lane_align u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .base(base), .offset(offset), .rt_data(rt_data),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_addr_lo(rsp_addr_lo), .rsp_rdata(rsp_rdata), .rsp_old(rsp_old),
    .wb_valid(wb_valid), .wb_data(wb_data)
  );

  typedef struct {
    string       tag;
    bit          mv;
    bit          mwe;
    logic [31:0] ma;
    logic [3:0]  mbe;
    logic [31:0] mwd;
    bit          wv;
    logic [31:0] wd;
  } exp_t;

  exp_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(logic [31:0] w, int n);
    return w[8*n +: 8];
  endfunction

  task automatic do_req(string tag, logic [5:0] op, logic [31:0] b, logic [15:0] off, logic [31:0] rt);
    exp_t e;
    logic [31:0] a;
    int kk;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; base = b; offset = off; rt_data = rt;
    rsp_valid = 1'b0;
    a = b + {{16{off[15]}}, off};
    kk = int'(a[1:0]);
    e.tag = tag; e.ma = a; e.mwd = 32'h0; e.mbe = 4'h0; e.wv = 1'b0; e.wd = 32'h0;
    e.mv = 1'b1; e.mwe = 1'b1;
    case (op)
      6'd40: begin e.mbe[kk] = 1'b1; e.mwd[8*kk +: 8] = rt[7:0]; end
      6'd41: for (int j = 0; j < 2; j++) begin
               e.mbe[2*a[1] + j] = 1'b1; e.mwd[8*(2*a[1] + j) +: 8] = byte_of(rt, j);
             end
      6'd43: begin e.mbe = 4'hF; e.mwd = rt; end
      6'd42: for (int j = 0; j <= kk; j++) begin
               e.mbe[j] = 1'b1; e.mwd[8*j +: 8] = byte_of(rt, 3 - kk + j);
             end
      6'd46: for (int j = kk; j < 4; j++) begin
               e.mbe[j] = 1'b1; e.mwd[8*j +: 8] = byte_of(rt, j - kk);
             end
      6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37, 6'd38: begin e.mwe = 1'b0; e.mbe = 4'hF; end
      default: begin e.mv = 1'b0; e.mwe = 1'b0; end
    endcase
    q.push_back(e);
  endtask

  task automatic do_rsp(string tag, logic [5:0] op, logic [1:0] lo, logic [31:0] rd, logic [31:0] old);
    exp_t e;
    int kk;
    logic [7:0]  bt;
    logic [15:0] hw;
    @(negedge clk);
    req_valid = 1'b0;
    rsp_valid = 1'b1; rsp_op = op; rsp_addr_lo = lo; rsp_rdata = rd; rsp_old = old;
    kk = int'(lo);
    bt = byte_of(rd, kk);
    hw = lo[1] ? rd[31:16] : rd[15:0];
    e.tag = tag; e.mv = 1'b0; e.mwe = 1'b0; e.ma = 0; e.mbe = 0; e.mwd = 0;
    e.wv = 1'b1; e.wd = old;
    case (op)
      6'd32: e.wd = bt[7] ? {24'hFFFFFF, bt} : {24'h0, bt};
      6'd36: e.wd = {24'h0, bt};
      6'd33: e.wd = hw[15] ? {16'hFFFF, hw} : {16'h0, hw};
      6'd37: e.wd = {16'h0, hw};
      6'd35: e.wd = rd;
      6'd34: for (int j = 0; j <= kk; j++) e.wd[8*(3 - kk + j) +: 8] = byte_of(rd, j);
      6'd38: for (int j = kk; j < 4; j++) e.wd[8*(j - kk) +: 8] = byte_of(rd, j);
      default: e.wv = 1'b0;
    endcase
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b0; rsp_valid = 1'b0;
    e.tag = tag; e.mv = 0; e.mwe = 0; e.ma = 0; e.mbe = 0; e.mwd = 0; e.wv = 0; e.wd = 0;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " mem_valid"}, mem_valid == e.mv, 32'(mem_valid), 32'(e.mv));
        chk({e.tag, " wb_valid"}, wb_valid == e.wv, 32'(wb_valid), 32'(e.wv));
        if (e.mv) begin
          chk({e.tag, " R1 mem_addr"}, mem_addr == e.ma, mem_addr, e.ma);
          chk({e.tag, " mem_we"}, mem_we == e.mwe, 32'(mem_we), 32'(e.mwe));
          chk({e.tag, " mem_be"}, mem_be == e.mbe, 32'(mem_be), 32'(e.mbe));
          if (e.mwe) begin
            logic [31:0] m;
            for (int j = 0; j < 4; j++) m[8*j +: 8] = {8{e.mbe[j]}};
            chk({e.tag, " mem_wdata"}, (mem_wdata & m) == (e.mwd & m), mem_wdata & m, e.mwd & m);
          end
        end
        if (e.wv) chk({e.tag, " wb_data"}, wb_data == e.wd, wb_data, e.wd);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R14 reset mem_valid", mem_valid == 1'b0, 32'(mem_valid), 32'h0);
    chk("R14 reset wb_valid", wb_valid == 1'b0, 32'(wb_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R14 post-reset mem_valid", mem_valid == 1'b0, 32'(mem_valid), 32'h0);
    chk("R14 post-reset wb_valid", wb_valid == 1'b0, 32'(wb_valid), 32'h0);

    for (int i = 0; i < 4; i++) do_req("R2 byte store", 6'd40, 32'h1000_0000, 16'(i), 32'hA1B2_C3D4);
    do_req("R1 negative offset byte store", 6'd40, 32'h0000_2003, 16'hFFFE, 32'h0000_0077);
    do_req("R3 half store low", 6'd41, 32'h2000_0000, 16'h0010, 32'h1234_5678);
    do_req("R3 half store high", 6'd41, 32'h2000_0000, 16'h0012, 32'h1234_5678);
    do_req("R4 word store", 6'd43, 32'h8000_0100, 16'hFF00, 32'hDEAD_BEEF);
    for (int i = 0; i < 4; i++) do_req("R5 left store", 6'd42, 32'h3000_0000, 16'(i), 32'h4433_2211);
    for (int i = 0; i < 4; i++) do_req("R6 right store", 6'd46, 32'h3000_0000, 16'(i), 32'h4433_2211);
    for (int i = 32; i <= 38; i++) do_req("R7 load request", 6'(i), 32'h4000_0001, 16'h0003, 32'h0);
    idle("R13 idle");
    do_req("R13 unknown op 39", 6'd39, 32'h5000_0000, 16'h0, 32'h1);
    do_req("R13 unknown op 0", 6'd0, 32'h5000_0000, 16'h0, 32'h1);

    for (int i = 0; i < 4; i++) do_rsp("R8 signed byte", 6'd32, 2'(i), 32'h80FF_7F01, 32'h5555_5555);
    for (int i = 0; i < 4; i++) do_rsp("R8 unsigned byte", 6'd36, 2'(i), 32'h80FF_7F01, 32'h5555_5555);
    do_rsp("R9 signed half low", 6'd33, 2'd0, 32'h7FFF_8001, 32'h0);
    do_rsp("R9 signed half high", 6'd33, 2'd2, 32'h7FFF_8001, 32'h0);
    do_rsp("R9 signed half high neg", 6'd33, 2'd2, 32'hC000_0001, 32'h0);
    do_rsp("R9 unsigned half low", 6'd37, 2'd0, 32'h7FFF_8001, 32'h0);
    do_rsp("R9 unsigned half high", 6'd37, 2'd2, 32'hC000_0001, 32'h0);
    do_rsp("R10 word load", 6'd35, 2'd0, 32'hCAFE_F00D, 32'h1111_1111);
    for (int i = 0; i < 4; i++) do_rsp("R11 left load", 6'd34, 2'(i), 32'hD3C3_B3A3, 32'h4433_2211);
    for (int i = 0; i < 4; i++) do_rsp("R12 right load", 6'd38, 2'(i), 32'hD3C3_B3A3, 32'h4433_2211);
    do_rsp("R13 store op on response", 6'd43, 2'd0, 32'h1, 32'h2);
    do_rsp("R13 unknown op on response", 6'd39, 2'd0, 32'h1, 32'h2);
    idle("R13 idle end");
    idle("drain");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule